// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

This block is a system timer for a register-bus peripheral space. It holds a free-running counter whose width is twice the compare width (64 bits by default) and four compare channels. The counter advances by one on every cycle in which the tick-enable input is high. That input is nominally one pulse per microsecond, so the counter reads as elapsed microseconds.

Each channel holds a compare value. On every tick, the channel checks that value against the low half of the counter. When the low half becomes equal to the compare value, the channel raises a sticky flag in a shared status word and drives its own interrupt line. Software clears a flag by writing a one to its bit in the status word. Because only the low half takes part in matching, software arms a channel for a point in time by writing `now + delay` into its compare register. That sum may wrap.

The bus is a plain 32-bit word interface. Writes take effect at the clock edge. Reads are combinational while read enable is high. The parameter `MATCH_W` (default 32) sets the compare width. The counter is `2*MATCH_W` bits wide, and narrower registers read back zero-extended.

Top module: `cmp_systimer`

## Requirements
- R1: There are four compare channels. Channel n's register sits at byte offset 0x0C+4n, is MATCH_W bits wide, and can be written at any time and read back. A write made in the same cycle as a tick changes the value only after that tick's match check.
- R2: The counter is 2*MATCH_W bits wide and increments by exactly one in each cycle where tick_i is 1, carrying from the low half into the high half. The low half reads at offset 0x04 and the high half at 0x08.
- R3: Status bit n (offset 0x00, bit n) is set at the clock edge at which a tick makes the counter's low half equal to channel n's compare value. No flag is set in a cycle without a tick.
- R4: irq_o[n] is high exactly when status bit n is set.
- R5: A write to offset 0x00 with a one in bit n clears flag n. Bits written as zero leave their flags unchanged.
- R6: A set flag stays set, even as the counter moves past the compare value, until it is cleared through R5.
- R7: If a match and a clear of the same channel happen in the same cycle, the flag ends up set.
- R8: Writes to offsets 0x04 and 0x08 have no effect. Offset 0x1C and any address with bus_addr[1:0] not 00 are unmapped: writes there have no effect and reads return zero. bus_rdata is zero whenever bus_re is 0.
- R9: A compare value that the low half has already passed matches only after the low half wraps around to it.
- R10: After reset, the counter, all compare registers and all flags are zero, and every irq_o bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per time unit |
| bus_addr | input | 5 | Byte address inside the 0x20 window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq_o | output | 4 | One interrupt per channel |

## Verification
Two functions can meet in one cycle: a tick that makes a channel match, and a status write that clears the same channel. The bench provokes this by programming a channel to the counter's next value and then issuing the tick and the clearing write in the same cycle. The flag is expected to survive. A second overlap is a compare write in a ticking cycle: the register is loaded with the counter's next low value, and the bench expects the old value to decide that cycle's match. Both cases are judged every clock against the behavioural reference and again by directed checks on irq_o.

// File: rtl/cmp_systimer_pkg.sv
// Package: shared constants and register index codes for the compare timer.
// Assumes a 32-bit bus and a 0x20-byte window addressed by byte.
package cmp_systimer_pkg;
    localparam int NCH = 4;   // compare channels
    localparam int DW  = 32;  // bus data width
    localparam int AW  = 5;   // byte address width of the window

    // Word index taken from bus_addr[4:2].
    typedef enum logic [2:0] {
        RI_STAT = 3'd0,
        RI_CLO  = 3'd1,
        RI_CHI  = 3'd2,
        RI_CMP0 = 3'd3,
        RI_CMP1 = 3'd4,
        RI_CMP2 = 3'd5,
        RI_CMP3 = 3'd6,
        RI_NONE = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/cst_counter.sv
// Module: free-running up counter for the compare timer.
// Advances by one in each cycle where tick is high. It also exposes the
// value the counter will hold after this edge, so compare logic can match
// on the tick that produces the value.
module cst_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx
);
    // Next count: incremented only on a tick.
    always_comb begin
        cnt_nx = tick ? cnt_q + W'(1) : cnt_q;
    end

    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/cst_channel.sv
// Module: one compare channel with a sticky flag.
// Assumes lo_nx is the counter's low half after the current edge. A match
// wins over a same-cycle acknowledge. A compare write lands after this
// cycle's check.
module cst_channel #(
    parameter int MW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [MW-1:0] lo_nx,
    input  logic          cmp_we,
    input  logic [MW-1:0] cmp_wd,
    input  logic          ack,
    output logic [MW-1:0] cmp_q,
    output logic          flag_q
);
    logic hit;

    // Match when this tick brings the low half onto the compare value.
    always_comb begin
        hit = tick && (lo_nx == cmp_q);
    end

    // Compare value register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wd;
    end

    // Sticky flag: set on hit, cleared by acknowledge, hit has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit | (flag_q & ~ack);
    end
endmodule

// File: rtl/cst_regbus.sv
// Module: register decode and read mux for the compare timer.
// Assumes word-aligned accesses. Misaligned addresses and index 7 decode
// to nothing. Read data is combinational and zero when bus_re is low.
module cst_regbus
    import cmp_systimer_pkg::*;
#(
    parameter int MW = 32
) (
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic                    bus_re,
    input  logic [NCH-1:0]          flags,
    input  logic [2*MW-1:0]         cnt,
    input  logic [NCH-1:0][MW-1:0]  cmp,
    output logic [NCH-1:0]          cmp_we,
    output logic [NCH-1:0]          ack,
    output logic [MW-1:0]           cmp_wd,
    output logic [DW-1:0]           bus_rdata
);
    reg_idx_e idx;
    logic     aligned;

    // Address split into word index and alignment check.
    always_comb begin
        idx     = reg_idx_e'(bus_addr[4:2]);
        aligned = (bus_addr[1:0] == 2'b00);
    end

    // Write decode: status acknowledge and per-channel compare strobes.
    always_comb begin
        cmp_wd = bus_wdata[MW-1:0];
        ack    = (bus_we && aligned && idx == RI_STAT) ? bus_wdata[NCH-1:0] : '0;
        for (int n = 0; n < NCH; n++) begin
            cmp_we[n] = bus_we && aligned && (idx == reg_idx_e'(int'(RI_CMP0) + n));
        end
    end

    // Read mux with zero extension of narrow fields.
    always_comb begin
        bus_rdata = '0;
        if (bus_re && aligned) begin
            case (idx)
                RI_STAT: bus_rdata[NCH-1:0] = flags;
                RI_CLO:  bus_rdata[MW-1:0]  = cnt[MW-1:0];
                RI_CHI:  bus_rdata[MW-1:0]  = cnt[2*MW-1:MW];
                RI_CMP0: bus_rdata[MW-1:0]  = cmp[0];
                RI_CMP1: bus_rdata[MW-1:0]  = cmp[1];
                RI_CMP2: bus_rdata[MW-1:0]  = cmp[2];
                RI_CMP3: bus_rdata[MW-1:0]  = cmp[3];
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmp_systimer.sv
// Module: top of the multi-channel compare system timer.
// Assumes MATCH_W <= 32 and a single-cycle tick_i pulse per time unit.
// Each channel's interrupt is its registered sticky flag.
module cmp_systimer
    import cmp_systimer_pkg::*;
#(
    parameter int MATCH_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] irq_o
);
    localparam int CW = 2 * MATCH_W;

    logic [CW-1:0]               cnt_q;
    logic [CW-1:0]               cnt_nx;
    logic [NCH-1:0][MATCH_W-1:0] cmp_q;
    logic [NCH-1:0]              flag_q;
    logic [NCH-1:0]              cmp_we;
    logic [NCH-1:0]              ack;
    logic [MATCH_W-1:0]          cmp_wd;

    cst_counter #(.W(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        cst_channel #(.MW(MATCH_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_i),
            .lo_nx  (cnt_nx[MATCH_W-1:0]),
            .cmp_we (cmp_we[n]),
            .cmp_wd (cmp_wd),
            .ack    (ack[n]),
            .cmp_q  (cmp_q[n]),
            .flag_q (flag_q[n])
        );
    end

    cst_regbus #(.MW(MATCH_W)) u_bus (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .flags     (flag_q),
        .cnt       (cnt_q),
        .cmp       (cmp_q),
        .cmp_we    (cmp_we),
        .ack       (ack),
        .cmp_wd    (cmp_wd),
        .bus_rdata (bus_rdata)
    );

    // Interrupt lines follow the sticky flags.
    always_comb begin
        irq_o = flag_q;
    end
endmodule

// File: rtl/cmp_systimer_chk.sv
// Module: assertion checker for the compare timer, bound to every instance.
// Observes only the top-level ports.
module cmp_systimer_chk
    import cmp_systimer_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_we,
    input logic [DW-1:0]  bus_wdata,
    input logic           bus_re,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] irq_o
);
    // R8: idle read port returns zero.
    always_comb begin
        if (rst_n && !bus_re) begin
            a_r8_rdata_idle: assert (bus_rdata == '0);
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R3: an interrupt can only rise after a tick.
        a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[n]) |-> $past(tick_i));

        // R6: a raised interrupt holds unless its bit is acknowledged.
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[n] && !(bus_we && bus_addr == 5'd0 && bus_wdata[n])) |=> irq_o[n]);

        // R5: an acknowledge without a competing tick drops the interrupt.
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == 5'd0 && bus_wdata[n] && !tick_i) |=> !irq_o[n]);
    end
endmodule

bind cmp_systimer cmp_systimer_chk u_chk (.*);

// File: tb/sim_cmp_systimer.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks that carry literal expected values.
module sim_cmp_systimer;
    localparam int MW = 8;
    localparam int CW = 2 * MW;
    localparam longint CMASK = (64'd1 << CW) - 1;
    localparam longint LMASK = (64'd1 << MW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    cmp_systimer #(.MATCH_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #2500ps clk = ~clk;

    // Reference model state.
    longint m_cnt;
    longint m_cmp [4];
    bit     m_flag [4];

    function automatic longint m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 0;
        case (a[4:2])
            3'd0: return {m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
            3'd1: return m_cnt & LMASK;
            3'd2: return (m_cnt >> MW) & LMASK;
            3'd3, 3'd4, 3'd5, 3'd6: return m_cmp[a[4:2] - 3];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_flag[i] = 0; end
        end else begin
            longint nx;
            nx = tick_i ? ((m_cnt + 1) & CMASK) : m_cnt;
            for (int i = 0; i < 4; i++) begin
                bit hit, clr;
                hit = tick_i && ((nx & LMASK) == m_cmp[i]);
                clr = bus_we && bus_addr == 5'd0 && bus_wdata[i];
                m_flag[i] = hit | (m_flag[i] & !clr);
            end
            for (int i = 0; i < 4; i++)
                if (bus_we && bus_addr == 5'(12 + 4 * i)) m_cmp[i] = bus_wdata & LMASK;
            m_cnt = nx;
        end
    end

    task automatic check(input string req, input longint got, input longint exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 irq vs model", longint'(irq_o),
                  longint'({m_flag[3], m_flag[2], m_flag[1], m_flag[0]}));
            if (bus_re) check("R1/R2/R3/R8 read vs model", longint'(bus_rdata), m_read(bus_addr));
            else        check("R8 idle rdata", longint'(bus_rdata), 0);
        end
    end

    // One bus cycle: inputs set 1ns after an edge and held through the next edge.
    task automatic drive(input bit t, input bit w, input logic [4:0] a, input logic [31:0] d);
        tick_i = t; bus_we = w; bus_addr = a; bus_wdata = d; bus_re = 1'b0;
        @(posedge clk); #1ns;
        tick_i = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) drive(1'b1, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_re = 1'b1; bus_addr = a;
        #1ns; v = bus_rdata;
        @(posedge clk); #1ns;
        bus_re = 1'b0; bus_addr = '0;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1ns; rst_n = 1'b1;
        // R10: reset state.
        check("R10 irq after reset", longint'(irq_o), 0);
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v); check("R10 register zero", longint'(v), 0);
        end
        // R1: compare write and readback.
        drive(0, 1, 5'h0C, 32'd5);
        rd(5'h0C, v); check("R1 cmp0 readback", longint'(v), 5);
        // R3: no match before the value is reached; match on the exact tick.
        ticks(4); check("R3 before match", longint'(irq_o), 0);
        ticks(1); check("R3 match sets irq0", longint'(irq_o), 1);
        rd(5'h00, v); check("R3 status bit0", longint'(v), 1);
        // R6: flag stays after counter passes.
        ticks(3); check("R6 sticky", longint'(irq_o), 1);
        // R5: zeros leave the flag, one clears it.
        drive(0, 1, 5'h00, 32'hE); check("R5 zero bits no effect", longint'(irq_o), 1);
        drive(0, 1, 5'h00, 32'h1); check("R5 clear bit0", longint'(irq_o), 0);
        // R1: independent channels (cnt = 8).
        drive(0, 1, 5'h10, 32'd10);
        drive(0, 1, 5'h18, 32'd12);
        repeat (3) drive(0, 0, 5'd0, 32'd0);
        check("R3 no tick no match", longint'(irq_o), 0);
        ticks(2); check("R1 channel1 alone", longint'(irq_o), 4'b0010);
        ticks(2); check("R1 channel3 added", longint'(irq_o), 4'b1010);
        drive(0, 1, 5'h00, 32'hF); check("R5 clear all", longint'(irq_o), 0);
        // R7: match and clear in the same cycle (cnt = 12).
        drive(0, 1, 5'h14, 32'd13);
        drive(1, 1, 5'h00, 32'h4); check("R7 match beats clear", longint'(irq_o), 4'b0100);
        drive(0, 1, 5'h00, 32'hF);
        // R9: value already passed (cnt = 13) matches only after wrap.
        drive(0, 1, 5'h0C, 32'd5);
        ticks(200); check("R9 no early match", longint'(irq_o), 0);
        ticks(47);  check("R9 one before wrap match", longint'(irq_o), 0);
        ticks(1);   check("R9 match after wrap", longint'(irq_o), 1);
        // R2: carry into the high half (cnt = 261).
        rd(5'h04, v); check("R2 low half", longint'(v), 5);
        rd(5'h08, v); check("R2 high half", longint'(v), 1);
        // R8: ignored writes and unmapped addresses.
        drive(0, 1, 5'h04, 32'hAA);
        drive(0, 1, 5'h08, 32'h55);
        rd(5'h04, v); check("R8 low half unchanged", longint'(v), 5);
        rd(5'h08, v); check("R8 high half unchanged", longint'(v), 1);
        drive(0, 1, 5'h1C, 32'h33);
        rd(5'h1C, v); check("R8 unmapped read zero", longint'(v), 0);
        drive(0, 1, 5'h12, 32'h77);
        rd(5'h10, v); check("R8 misaligned write ignored", longint'(v), 10);
        rd(5'h11, v); check("R8 misaligned read zero", longint'(v), 0);
        // R1: compare write in a ticking cycle uses the old value (cnt = 261, lo 5).
        drive(0, 1, 5'h00, 32'hF);
        drive(1, 1, 5'h18, 32'd6);
        check("R1 write during tick no match", longint'(irq_o), 0);
        rd(5'h18, v); check("R1 new value stored", longint'(v), 6);
        ticks(256); check("R1 new value matches on wrap", longint'(irq_o[3]), 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule